// File: doc/BRIEF.md
# Double-Buffered Audio Sample Player

This block plays stored audio samples out to a DAC interface at a fixed sample rate, while the CPU refills the store in parallel. The sample store is split into a lower and an upper half, selected by the top address bit. One half is read out, one entry per sample strobe, while software writes the other. When the read pointer leaves the last entry of a half and enters the other half, the block raises a sticky interrupt. Software then knows that the half just finished is free to refill. The sample strobe arrives as a clock-enable pulse, so all playback timing comes from the strobe source and not from a CPU timer.

Each stored word has two parts: a sample and a presence marker, nine bits in total at the default width. A CPU write stores the sample and sets the marker. Playing a word clears its marker, so an entry that has not been refilled is never played a second time. When the word under the pointer has no marker, the output keeps the last good sample, a sticky underrun flag is set, and the pointer still advances. With the default depth of 2048 entries at 48 kHz, each half lasts about 21 ms. Software therefore services the block a few dozen times per second.

The controller has two states. `ST_IDLE` is entered after reset and whenever `enable` is low. In this state the pointer is held at entry 0. The transition `ST_IDLE -> ST_RUN` (arm) happens on the first clock edge with `enable` high. In `ST_RUN`, each strobe plays one entry. The transition `ST_RUN -> ST_IDLE` (stop) happens on the first edge with `enable` low, and it rewinds the pointer.

Top module: `dbuf_player`

## Requirements
- R1: After reset, `irq`, `underrun`, `play_half`, `dac_valid` and `dac_data` are all 0, every presence marker is clear, and the controller is in `ST_IDLE`.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr` and sets that entry's presence marker. Writes are accepted in any state and at any address.
- R3: A strobe (`sample_tick` high) is acted on only when the controller is in `ST_RUN` and `enable` is high. When it is acted on, `dac_valid` is high for exactly the one cycle after that edge. Strobes at any other time change neither `dac_data` nor `dac_valid`.
- R4: Entries are played in ascending address order and wrap from the last entry to entry 0. `play_half` equals the top address bit of the entry that will be played next (0 = lower half).
- R5: Playing an entry whose marker is set loads its sample into `dac_data` on the strobe edge and clears the marker. A second pass over that entry without a refill is treated as empty.
- R6: Playing an entry whose marker is clear leaves `dac_data` unchanged, sets the sticky `underrun` flag, and still advances the pointer.
- R7: On the strobe edge that plays the last entry of a half, `play_half` toggles and `irq` is set. `irq` stays set until a cycle with `irq_ack` high. If set and acknowledge fall in the same cycle, the set wins.
- R8: `underrun` stays set until a cycle with `uflow_ack` high. If a new empty read and the acknowledge fall in the same cycle, the flag stays set.
- R9: If a CPU write targets the entry being played in the same cycle, the old content is played and the new sample stays stored with its marker set. The new sample is then played on the next pass over that entry.
- R10: The stop transition returns the pointer to entry 0, so `play_half` becomes 0. `irq` and `underrun` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Playback run request |
| sample_tick | input | 1 | Sample-rate clock-enable strobe |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | ADDR_W | CPU write entry index |
| wr_data | input | DATA_W | CPU sample value |
| irq_ack | input | 1 | Clears the half-switch interrupt |
| uflow_ack | input | 1 | Clears the underrun flag |
| dac_data | output | DATA_W | Sample currently presented to the DAC |
| dac_valid | output | 1 | One-cycle pulse after each played strobe |
| irq | output | 1 | Sticky half-switch interrupt |
| underrun | output | 1 | Sticky empty-entry flag |
| play_half | output | 1 | Half that the next strobe reads from |

## Verification
Two pairs of events can fall in one cycle. The first is a CPU write and the playback scrub of the same entry. The bench provokes it by asserting `wr_en` at the pointer's address together with a strobe. It judges the result twice: the played value must be the old sample, and a full lap later the new sample must appear. The second pair is a flag event and its acknowledge. The bench asserts `irq_ack` on the strobe that crosses a half boundary, and `uflow_ack` on a strobe that reads an empty entry. Both flags must read as set afterwards.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } play_state_t;
endpackage

// File: rtl/dbuf_store.sv
// Sample store: a data array plus one presence marker per entry.
module dbuf_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              scrub,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mark
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  mark;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // A CPU write is applied after the scrub, so it wins on the same entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark <= '0;
        end else begin
            if (scrub) mark[rd_addr] <= 1'b0;
            if (wr_en) mark[wr_addr] <= 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];
    assign rd_mark = mark[rd_addr];
endmodule

// File: rtl/dbuf_ctrl.sv
// Playback controller: run state, read pointer, DAC output register.
module dbuf_ctrl
    import dbuf_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              rd_mark,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              scrub,
    output logic              half_done,
    output logic              starve,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_valid,
    output logic              play_half
);
    localparam int LOW_W = ADDR_W - 1;

    play_state_t       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic              play_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)  state_d = ST_RUN;   // arm
            ST_RUN:  if (!enable) state_d = ST_IDLE;  // stop
            default: state_d = ST_IDLE;
        endcase
    end

    assign play_now  = (state_q == ST_RUN) && enable && tick;
    assign scrub     = play_now && rd_mark;
    assign starve    = play_now && !rd_mark;
    assign half_done = play_now && (ptr_q[LOW_W-1:0] == {LOW_W{1'b1}});
    assign rd_addr   = ptr_q;
    assign play_half = ptr_q[ADDR_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            dac_data  <= '0;
            dac_valid <= 1'b0;
        end else begin
            dac_valid <= play_now;
            if (state_d == ST_IDLE) ptr_q <= '0;
            else if (play_now)      ptr_q <= ptr_q + 1'b1;
            if (scrub) dac_data <= rd_data;
        end
    end
endmodule

// File: rtl/dbuf_flag.sv
// Sticky event flag; a set event wins over an acknowledge in the same cycle.
module dbuf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (ack)     flag <= 1'b0;
    end
endmodule

// File: rtl/dbuf_player.sv
module dbuf_player #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sample_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_ack,
    input  logic              uflow_ack,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_valid,
    output logic              irq,
    output logic              underrun,
    output logic              play_half
);
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              rd_mark, scrub, half_done, starve;

    dbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .scrub(scrub),
        .rd_data(rd_data), .rd_mark(rd_mark)
    );

    dbuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(sample_tick),
        .rd_mark(rd_mark), .rd_data(rd_data), .rd_addr(rd_addr),
        .scrub(scrub), .half_done(half_done), .starve(starve),
        .dac_data(dac_data), .dac_valid(dac_valid), .play_half(play_half)
    );

    dbuf_flag u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(half_done), .ack(irq_ack), .flag(irq)
    );

    dbuf_flag u_uflow (
        .clk(clk), .rst_n(rst_n), .set_evt(starve), .ack(uflow_ack), .flag(underrun)
    );
endmodule

// File: rtl/dbuf_player_chk.sv
module dbuf_player_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              sample_tick,
    input logic              irq_ack,
    input logic              uflow_ack,
    input logic [DATA_W-1:0] dac_data,
    input logic              dac_valid,
    input logic              irq,
    input logic              underrun,
    input logic              play_half
);
    // R3: a valid pulse only follows an enabled strobe
    a_r3_valid_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> ($past(sample_tick) && $past(enable)));

    // R6: the output word only moves together with a valid pulse
    a_r6_data_moves_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_data != $past(dac_data)) |-> dac_valid);

    // R4: without a strobe the playing half stays put while running
    a_r4_half_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !$past(sample_tick)) |-> $stable(play_half));

    // R7: a half switch during playback always leaves the interrupt set
    a_r7_irq_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && (play_half != $past(play_half))) |-> irq);

    // R7: interrupt is sticky until acknowledged
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R8: underrun is sticky until acknowledged
    a_r8_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !uflow_ack) |=> underrun);
endmodule

bind dbuf_player dbuf_player_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_tick(sample_tick),
    .irq_ack(irq_ack), .uflow_ack(uflow_ack), .dac_data(dac_data),
    .dac_valid(dac_valid), .irq(irq), .underrun(underrun), .play_half(play_half)
);

// File: tb/dbuf_player_bench.sv
module dbuf_player_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  AW = 4;
    localparam int  DW = 8;
    localparam int  HALF = 1 << (AW - 1);

    // {write?, sample, expected dac_data, expected underrun} for entries 0..7
    localparam logic [17:0] VEC [8] = '{
        {1'b1, 8'h11, 8'h11, 1'b0},
        {1'b1, 8'h22, 8'h22, 1'b0},
        {1'b0, 8'h00, 8'h22, 1'b1},
        {1'b1, 8'h44, 8'h44, 1'b1},
        {1'b1, 8'h55, 8'h55, 1'b1},
        {1'b0, 8'h00, 8'h55, 1'b1},
        {1'b1, 8'h77, 8'h77, 1'b1},
        {1'b1, 8'h88, 8'h88, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0, sample_tick = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          irq_ack = 1'b0, uflow_ack = 1'b0;
    logic [DW-1:0] dac_data;
    logic          dac_valid, irq, underrun, play_half;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbuf_player #(.ADDR_W(AW), .DATA_W(DW)) u_dbuf_player (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample_tick(sample_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_ack(irq_ack), .uflow_ack(uflow_ack), .dac_data(dac_data),
        .dac_valid(dac_valid), .irq(irq), .underrun(underrun), .play_half(play_half)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, driven from a falling edge to the next one.
    task automatic step(input bit tk, input bit wr, input int addr, input logic [DW-1:0] d,
                        input bit iack, input bit uack);
        @(negedge clk);
        sample_tick = tk; wr_en = wr; wr_addr = addr[AW-1:0]; wr_data = d;
        irq_ack = iack; uflow_ack = uack;
        @(negedge clk);
        sample_tick = 1'b0; wr_en = 1'b0; irq_ack = 1'b0; uflow_ack = 1'b0;
    endtask

    task automatic write(input int addr, input logic [DW-1:0] d);
        step(1'b0, 1'b1, addr, d, 1'b0, 1'b0);
    endtask

    task automatic tick();
        step(1'b1, 1'b0, 0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 play_half", play_half, 0);
        chk("R1 dac_valid", dac_valid, 0);
        chk("R1 dac_data", dac_data, 0);

        // R3: strobe while idle is ignored
        tick();
        chk("R3 idle tick valid", dac_valid, 0);
        chk("R3 idle tick data", dac_data, 0);

        // R2: fill the lower half from the table
        for (int i = 0; i < HALF; i++)
            if (VEC[i][17]) write(i, VEC[i][16:9]);

        @(negedge clk); enable = 1'b1;   // arm on next edge

        // R4/R5/R6/R7: play the lower half in order
        for (int i = 0; i < HALF; i++) begin
            tick();
            chk($sformatf("R5 R6 data entry %0d", i), dac_data, VEC[i][8:1]);
            chk($sformatf("R3 valid entry %0d", i), dac_valid, 1);
            chk($sformatf("R6 underrun entry %0d", i), underrun, VEC[i][0]);
            chk($sformatf("R4 half entry %0d", i), play_half, (i == HALF-1));
            chk($sformatf("R7 irq entry %0d", i), irq, (i == HALF-1));
        end
        @(negedge clk);
        chk("R3 valid single cycle", dac_valid, 0);
        chk("R7 irq held", irq, 1);

        step(1'b0, 1'b0, 0, '0, 1'b1, 1'b1);
        chk("R7 irq acked", irq, 0);
        chk("R8 underrun acked", underrun, 0);

        // R9: write the entry under the pointer in the strobe cycle
        write(HALF, 8'hA1);
        step(1'b1, 1'b1, HALF, 8'hB2, 1'b0, 1'b0);
        chk("R9 old value played", dac_data, 8'hA1);
        chk("R9 no underrun", underrun, 0);

        for (int i = HALF + 1; i < 2*HALF - 1; i++) tick();
        chk("R6 empty entries hold data", dac_data, 8'hA1);
        chk("R6 empty entries underrun", underrun, 1);

        // R7: ack in the same cycle as the wrap set -> set wins
        step(1'b1, 1'b0, 0, '0, 1'b1, 1'b0);
        chk("R7 set beats ack", irq, 1);
        chk("R4 wrap to lower half", play_half, 0);

        step(1'b0, 1'b0, 0, '0, 1'b0, 1'b1);
        chk("R8 ack alone", underrun, 0);

        // R5: entry 0 was played and not refilled
        tick();
        chk("R5 no replay underrun", underrun, 1);
        chk("R5 no replay data", dac_data, 8'hA1);

        // R8: empty read and ack together -> set wins
        step(1'b1, 1'b0, 0, '0, 1'b0, 1'b1);
        chk("R8 set beats ack", underrun, 1);

        for (int i = 2; i < HALF; i++) tick();
        chk("R4 upper half again", play_half, 1);
        tick();
        chk("R9 new sample kept", dac_data, 8'hB2);

        // R10: stop rewinds, flags kept
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        chk("R10 half rewound", play_half, 0);
        chk("R10 irq kept", irq, 1);
        chk("R10 underrun kept", underrun, 1);
        tick();
        chk("R3 disabled tick valid", dac_valid, 0);
        chk("R3 disabled tick data", dac_data, 8'hB2);

        write(0, 8'h5A);
        @(negedge clk); enable = 1'b1;
        tick();
        chk("R10 restart at entry 0", dac_data, 8'h5A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule